// File: doc/BRIEF.md
# XNOR-Feedback Pseudo-Random Counter

This block is a shift-register counter that steps through a long, fixed, pseudo-random sequence of codes. It needs no carry chain. On each clock with the advance input high, every stage moves one place to the right. The leftmost stage takes a new bit, the inverted exclusive-OR of the tapped stages. The block fits places that need a fast counter but do not care about count order, such as pointer wrap detection or dwell timers.

Stages are numbered 1 to N from left to right. Stage k is register bit N-k, so stage 1 is the most significant bit and stage N is bit 0. The register width and the tap set are parameters. The tap set is a mask: mask bit k-1 set means stage k feeds the feedback gate. Because the feedback is inverted, all zeros is a valid start value. All ones is the one state the counter must never enter: once there, it would stay there for good. Reset loads all zeros, which lies on the long cycle.

Top module: `lfsr_xnor_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes all zeros at that edge.
- R2: On a rising edge with `rst` low and `advance` high, each bit `count[i]` for i < N-1 takes the old value of `count[i+1]` (shift right by one).
- R3: On the same edge, the new `count[N-1]` (stage 1) is the XNOR of the old bits at the tapped stages. Stage k is bit N-k, and mask bit k-1 selects it.
- R4: On a rising edge with `rst` low and `advance` low, `count` keeps its value.
- R5: Starting from reset, `count` never reaches all ones.
- R6: With the default build (4 stages, taps at stages 4 and 3), the counter visits 15 distinct codes. It returns to all zeros after exactly 15 advances, and no code repeats before then.
- R7: Reset takes priority over `advance`: with both high, the state still becomes all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, loads all zeros |
| advance | input | 1 | Step enable; low holds the state |
| count | output | WIDTH | Present register state; stage 1 is the MSB |

## Verification
The bench builds the block with its default parameters: four stages, with stages 4 and 3 tapped. At this size the whole state space has sixteen codes, so a short directed run can walk the full cycle. It can show that every code except all ones is visited, and that the period is exactly fifteen. The same run checks each single step against a bench-side model of the shift and inverted-parity rule. It also covers holding, reset during a run, and reset taking priority over `advance`.

// File: rtl/lfsr_xnor_pkg.sv
package lfsr_xnor_pkg;

    localparam int unsigned DEF_WIDTH = 4;
    localparam logic [DEF_WIDTH-1:0] DEF_TAP_MASK = 4'b1100; // stages 4 and 3

    // Number of tapped stages in a mask
    function automatic int unsigned tap_count(input logic [63:0] mask, input int unsigned width);
        int unsigned n;
        n = 0;
        for (int unsigned i = 0; i < width; i++) begin
            if (mask[i]) n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/lfsr_xnor_tap.sv
// Feedback gate: inverted parity of the tapped stages.
module lfsr_xnor_tap #(
    parameter int unsigned      WIDTH    = 4,
    parameter logic [WIDTH-1:0] TAP_MASK = 4'b1100
) (
    input  logic [WIDTH-1:0] state_i,
    output logic             fb_o
);
    // Stage k maps to register bit WIDTH-k; mask bit k-1 selects stage k.
    logic [WIDTH-1:0] picked;

    for (genvar k = 1; k <= WIDTH; k++) begin : g_stage
        if (TAP_MASK[k-1]) begin : g_on
            assign picked[WIDTH-k] = state_i[WIDTH-k];
        end else begin : g_off
            assign picked[WIDTH-k] = 1'b0;
        end
    end

    assign fb_o = ~(^picked);
endmodule

// File: rtl/lfsr_xnor_shift.sv
// Right shift with the feedback bit entering stage 1 (the MSB).
module lfsr_xnor_shift #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] state_i,
    input  logic             fb_i,
    output logic [WIDTH-1:0] state_o
);
    assign state_o[WIDTH-1] = fb_i;

    for (genvar i = 0; i < WIDTH-1; i++) begin : g_move
        assign state_o[i] = state_i[i+1];
    end
endmodule

// File: rtl/lfsr_xnor_counter.sv
module lfsr_xnor_counter
    import lfsr_xnor_pkg::*;
#(
    parameter int unsigned      WIDTH    = DEF_WIDTH,
    parameter logic [WIDTH-1:0] TAP_MASK = DEF_TAP_MASK
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [WIDTH-1:0] count
);
    localparam logic [WIDTH-1:0] SEED = '0;

    typedef struct packed {
        logic [WIDTH-1:0] state;
    } regs_t;

    regs_t            regs_d, regs_q;
    logic             fb;
    logic [WIDTH-1:0] stepped;

    lfsr_xnor_tap #(
        .WIDTH    (WIDTH),
        .TAP_MASK (TAP_MASK)
    ) i_tap (
        .state_i (regs_q.state),
        .fb_o    (fb)
    );

    lfsr_xnor_shift #(
        .WIDTH (WIDTH)
    ) i_shift (
        .state_i (regs_q.state),
        .fb_i    (fb),
        .state_o (stepped)
    );

    always_comb begin
        regs_d = regs_q;
        if (rst) begin
            regs_d.state = SEED;
        end else if (advance) begin
            regs_d.state = stepped;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign count = regs_q.state;
endmodule

// File: rtl/lfsr_xnor_counter_chk.sv
module lfsr_xnor_counter_chk #(
    parameter int unsigned      WIDTH    = 4,
    parameter logic [WIDTH-1:0] TAP_MASK = 4'b1100
) (
    input logic             clk,
    input logic             rst,
    input logic             advance,
    input logic [WIDTH-1:0] count
);
    // R1 and R7: reset wins over advance
    a_r1_reset_zero: assert property (@(posedge clk) rst |=> count == '0);
    a_r7_reset_priority: assert property (@(posedge clk) (rst && advance) |=> count == '0);

    // R2: shift right
    a_r2_shift_right: assert property (@(posedge clk) disable iff (rst)
        advance |=> count[WIDTH-2:0] == $past(count[WIDTH-1:1]));

    // R3: inverted parity of the old tapped bits lands in the MSB
    a_r3_feedback: assert property (@(posedge clk) disable iff (rst)
        advance |=> count[WIDTH-1] == ~(^($past(count) & {<<{TAP_MASK}})));

    // R4: hold
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(count));

    // R5: lock-up code never seen
    a_r5_no_lockup: assert property (@(posedge clk) disable iff (rst)
        count != '1);
endmodule

bind lfsr_xnor_counter lfsr_xnor_counter_chk #(
    .WIDTH    (WIDTH),
    .TAP_MASK (TAP_MASK)
) i_chk (
    .clk     (clk),
    .rst     (rst),
    .advance (advance),
    .count   (count)
);

// File: tb/test_lfsr_xnor_counter.sv
`timescale 1ns/1ps
module test_lfsr_xnor_counter;
    localparam int W = 4;
    localparam logic [W-1:0] MASK = 4'b1100;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         advance = 1'b0;
    logic [W-1:0] count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    lfsr_xnor_counter #(.WIDTH(W), .TAP_MASK(MASK)) i_lfsr_xnor_counter (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .count   (count)
    );

    // Bench model from R2/R3: stage k is bit W-k, mask bit k-1 selects it.
    function automatic logic [W-1:0] model_next(input logic [W-1:0] s);
        logic p;
        p = 1'b0;
        for (int k = 1; k <= W; k++) begin
            if (MASK[k-1]) p = p ^ s[W-k];
        end
        return {~p, s[W-1:1]};
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Drive at the falling edge, one rising edge, sample 1 ns after it.
    task automatic step(input logic r, input logic a);
        @(negedge clk);
        rst = r;
        advance = a;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        step(1'b1, 1'b0);
        check("R1 reset", count, '0);
    endtask

    task automatic t_full_period();
        logic [W-1:0] prev;
        bit seen [16];
        bit lock;
        for (int i = 0; i < 16; i++) seen[i] = 1'b0;
        step(1'b1, 1'b0);
        seen[0] = 1'b1;
        lock = 1'b0;
        for (int n = 1; n <= 15; n++) begin
            prev = count;
            step(1'b0, 1'b1);
            check("R2/R3 step", count, model_next(prev));
            if (count == '1) lock = 1'b1;
            if (n < 15) begin
                checks++;
                if (seen[count]) begin
                    errors++;
                    $display("FAIL R6 repeat at step %0d actual=%b expected=new code", n, count);
                end
            end
            seen[count] = 1'b1;
        end
        check("R6 back to zero after 15", count, '0);
        check("R5 all ones never seen", {3'b000, lock}, '0);
    endtask

    task automatic t_known_codes();
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        check("R3 first code", count, 4'b1000);
        step(1'b0, 1'b1);
        check("R3 second code", count, 4'b1100);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        check("R2 fourth code", count, 4'b0111);
    endtask

    task automatic t_hold();
        logic [W-1:0] keep;
        keep = count;
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b0);
            check("R4 hold", count, keep);
        end
        step(1'b0, 1'b1);
        check("R4 resume", count, model_next(keep));
    endtask

    task automatic t_reset_priority();
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        check("R7 reset over advance", count, '0);
        step(1'b0, 1'b1);
        check("R1 restart after reset", count, 4'b1000);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_known_codes();
        t_hold();
        t_full_period();
        t_reset_priority();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule